// File: doc/BRIEF.md
# MIPS Subset Instruction Decoder and Control Unit

This block is the combinational decode stage of a single-cycle processor that runs a ten-instruction MIPS subset. It covers add, sub, and, or, slt, addi, lw, sw, beq and j. It takes the fetched 32-bit instruction word and the already incremented program counter (PC+4). It splits the word into its fields and drives the datapath steering signals from the opcode. It also derives the 4-bit ALU operation from the ALU class and the function code, chooses the destination register number, and sign-extends the immediate.

The block computes both next-PC candidates itself: the conditional-branch target and the jump target. The surrounding core keeps the register file, ALU, memories and the PC register, and uses these outputs to steer them. Every control output is fully specified. A value that the datapath would ignore is still driven to 0, and an opcode outside the subset produces an all-zero control word. The block has no state, so each output is a function of the current inputs only.

Top module: `mdec_decode`

## Requirements
- R1: Fields come from fixed bit positions: opcode [31:26], rs [25:21], rt [20:16], rd [15:11], funct [5:0], immediate [15:0].
- R2: Opcode 000000 (R-type) gives reg_dst=1, alu_src=0, mem_to_reg=0, reg_write=1, mem_read=0, mem_write=0, branch=0, jump=0, alu_op=10.
- R3: Opcode 100011 (load word) gives reg_dst=0, alu_src=1, mem_to_reg=1, reg_write=1, mem_read=1, mem_write=0, branch=0, jump=0, alu_op=00.
- R4: Opcode 101011 (store word) gives alu_src=1, mem_write=1, alu_op=00, with every other control output 0.
- R5: Opcode 000100 (branch if equal) gives branch=1, alu_op=01, with every other control output 0.
- R6: Opcode 001000 (add immediate) gives alu_src=1, reg_write=1, alu_op=00, with every other control output 0 (reg_dst=0 and mem_to_reg=0).
- R7: Opcode 000010 (jump) gives jump=1, alu_op=00, with every other control output 0.
- R8: Any other opcode drives all eight 1-bit control outputs and alu_op to 0.
- R9: alu_op=00 yields ALU operation 0010 (add), and alu_op=01 yields 0110 (subtract), whatever the funct field holds.
- R10: With alu_op=10 the ALU operation follows funct: 100000 gives 0010, 100010 gives 0110, 100100 gives 0000, 100101 gives 0001, 101010 gives 0111. Any other funct gives 0000.
- R11: The write register number is rd when reg_dst=1 and rt otherwise.
- R12: The 32-bit extended immediate equals the two's-complement value of instruction bits [15:0]; bits [31:16] copy bit 15.
- R13: The branch target equals PC+4 plus four times the extended immediate, modulo 2^32.
- R14: The jump target is PC+4 bits [31:28], followed by instruction bits [25:0], followed by two zero bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr_i | input | 32 | Instruction word being decoded |
| pc_plus4_i | input | 32 | Address of the instruction plus 4 |
| opcode_o | output | 6 | Opcode field |
| rs_o | output | 5 | First source register number |
| rt_o | output | 5 | Second source / immediate destination register number |
| rd_o | output | 5 | R-type destination register number |
| funct_o | output | 6 | Function code field |
| imm_o | output | 16 | Raw immediate field |
| reg_dst_o | output | 1 | 1 selects rd as write register, 0 selects rt |
| alu_src_o | output | 1 | 1 takes the extended immediate as ALU operand B |
| mem_to_reg_o | output | 1 | 1 writes memory read data back to the register file |
| reg_write_o | output | 1 | Register file write enable |
| mem_read_o | output | 1 | Data memory read enable |
| mem_write_o | output | 1 | Data memory write enable |
| branch_o | output | 1 | Instruction is a conditional branch |
| jump_o | output | 1 | Instruction is an unconditional jump |
| alu_op_o | output | 2 | ALU class: 00 add, 01 subtract, 10 per funct |
| alu_ctl_o | output | 4 | ALU operation code |
| wr_reg_o | output | 5 | Selected write register number |
| imm_ext_o | output | 32 | Sign-extended immediate |
| branch_tgt_o | output | 32 | Conditional branch target address |
| jump_tgt_o | output | 32 | Jump target address |

## Verification
The bench walks all 64 opcode values with scrambled lower bits. This separates each of the six supported control words from the all-zero word of the undefined codes. It also shows that no field other than the opcode leaks into the controls. All 64 function codes are then applied under the R-type opcode, which tells the five arithmetic and logic selections apart from the zero default. A sweep of 1024 immediates runs with varying PC+4 values and covers the sign boundary at 0x7FFF/0x8000 and the value 0xFFFF. It tells correct sign extension apart from zero extension, and a wrapped branch sum apart from a truncated one. The same sweep shows that the jump target keeps only the top nibble of PC+4.

// File: rtl/mdec_pkg.sv
package mdec_pkg;

   localparam logic [5:0] OPC_RTYPE = 6'b000000;
   localparam logic [5:0] OPC_ADDI  = 6'b001000;
   localparam logic [5:0] OPC_LW    = 6'b100011;
   localparam logic [5:0] OPC_SW    = 6'b101011;
   localparam logic [5:0] OPC_BEQ   = 6'b000100;
   localparam logic [5:0] OPC_J     = 6'b000010;

   localparam logic [5:0] FN_ADD = 6'b100000;
   localparam logic [5:0] FN_SUB = 6'b100010;
   localparam logic [5:0] FN_AND = 6'b100100;
   localparam logic [5:0] FN_OR  = 6'b100101;
   localparam logic [5:0] FN_SLT = 6'b101010;

   typedef enum logic [1:0] {
      ALUCLS_ADD   = 2'b00,
      ALUCLS_SUB   = 2'b01,
      ALUCLS_FUNCT = 2'b10,
      ALUCLS_RSVD  = 2'b11
   } alu_cls_e;

   typedef enum logic [3:0] {
      ALU_AND = 4'b0000,
      ALU_OR  = 4'b0001,
      ALU_ADD = 4'b0010,
      ALU_SUB = 4'b0110,
      ALU_SLT = 4'b0111
   } alu_ctl_e;

   typedef struct packed {
      logic     reg_dst;
      logic     alu_src;
      logic     mem_to_reg;
      logic     reg_write;
      logic     mem_read;
      logic     mem_write;
      logic     branch;
      logic     jump;
      alu_cls_e alu_cls;
   } ctrl_t;

endpackage

// File: rtl/mdec_fields.sv
module mdec_fields #(
   parameter int INSTR_W = 32,
   parameter int OPC_W   = 6,
   parameter int REG_AW  = 5,
   parameter int FN_W    = 6,
   parameter int IMM_W   = 16,
   parameter int JIDX_W  = 26
) (
   input  logic [INSTR_W-1:0] instr,
   output logic [OPC_W-1:0]   opcode,
   output logic [REG_AW-1:0]  rs,
   output logic [REG_AW-1:0]  rt,
   output logic [REG_AW-1:0]  rd,
   output logic [FN_W-1:0]    funct,
   output logic [IMM_W-1:0]   imm,
   output logic [JIDX_W-1:0]  jidx
);
   localparam int OPC_LSB = INSTR_W - OPC_W;
   localparam int RS_LSB  = OPC_LSB - REG_AW;
   localparam int RT_LSB  = RS_LSB - REG_AW;
   localparam int RD_LSB  = RT_LSB - REG_AW;

   if (OPC_LSB != JIDX_W) begin : g_bad_jidx
      $error("mdec_fields: opcode and jump index must tile the word");
   end
   if (RD_LSB < FN_W) begin : g_bad_rd
      $error("mdec_fields: rd overlaps funct");
   end

   assign opcode = instr[OPC_LSB +: OPC_W];
   assign rs     = instr[RS_LSB  +: REG_AW];
   assign rt     = instr[RT_LSB  +: REG_AW];
   assign rd     = instr[RD_LSB  +: REG_AW];
   assign funct  = instr[0 +: FN_W];
   assign imm    = instr[0 +: IMM_W];
   assign jidx   = instr[0 +: JIDX_W];
endmodule

// File: rtl/mdec_main_ctrl.sv
module mdec_main_ctrl
   import mdec_pkg::*;
(
   input  logic [5:0] opcode,
   output ctrl_t      ctrl
);
   always_comb begin
      ctrl = '0;
      unique case (opcode)
         OPC_RTYPE: begin
            ctrl.reg_dst   = 1'b1;
            ctrl.reg_write = 1'b1;
            ctrl.alu_cls   = ALUCLS_FUNCT;
         end
         OPC_LW: begin
            ctrl.alu_src    = 1'b1;
            ctrl.mem_to_reg = 1'b1;
            ctrl.reg_write  = 1'b1;
            ctrl.mem_read   = 1'b1;
            ctrl.alu_cls    = ALUCLS_ADD;
         end
         OPC_SW: begin
            ctrl.alu_src   = 1'b1;
            ctrl.mem_write = 1'b1;
            ctrl.alu_cls   = ALUCLS_ADD;
         end
         OPC_BEQ: begin
            ctrl.branch  = 1'b1;
            ctrl.alu_cls = ALUCLS_SUB;
         end
         OPC_ADDI: begin
            ctrl.alu_src   = 1'b1;
            ctrl.reg_write = 1'b1;
            ctrl.alu_cls   = ALUCLS_ADD;
         end
         OPC_J: begin
            ctrl.jump = 1'b1;
         end
         default: ctrl = '0;
      endcase
   end
endmodule

// File: rtl/mdec_alu_ctrl.sv
module mdec_alu_ctrl
   import mdec_pkg::*;
(
   input  alu_cls_e   alu_cls,
   input  logic [5:0] funct,
   output alu_ctl_e   alu_ctl
);
   alu_ctl_e fn_ctl;

   always_comb begin
      unique case (funct)
         FN_ADD:  fn_ctl = ALU_ADD;
         FN_SUB:  fn_ctl = ALU_SUB;
         FN_AND:  fn_ctl = ALU_AND;
         FN_OR:   fn_ctl = ALU_OR;
         FN_SLT:  fn_ctl = ALU_SLT;
         default: fn_ctl = ALU_AND;
      endcase
   end

   always_comb begin
      unique case (alu_cls)
         ALUCLS_ADD:   alu_ctl = ALU_ADD;
         ALUCLS_SUB:   alu_ctl = ALU_SUB;
         ALUCLS_FUNCT: alu_ctl = fn_ctl;
         default:      alu_ctl = ALU_AND;
      endcase
   end
endmodule

// File: rtl/mdec_sext.sv
module mdec_sext #(
   parameter int IN_W   = 16,
   parameter int OUT_W  = 32,
   parameter bit SIGNED = 1'b1
) (
   input  logic [IN_W-1:0]  din,
   output logic [OUT_W-1:0] dout
);
   localparam int PAD_W = OUT_W - IN_W;

   if (PAD_W < 0) begin : g_bad_w
      $error("mdec_sext: output narrower than input");
   end else if (PAD_W == 0) begin : g_pass
      assign dout = din;
   end else if (SIGNED) begin : g_sign
      assign dout = {{PAD_W{din[IN_W-1]}}, din};
   end else begin : g_zero
      assign dout = {{PAD_W{1'b0}}, din};
   end
endmodule

// File: rtl/mdec_targets.sv
module mdec_targets #(
   parameter int XLEN   = 32,
   parameter int JIDX_W = 26,
   parameter int ALIGN  = 2
) (
   input  logic [XLEN-1:0]   pc_plus4,
   input  logic [XLEN-1:0]   imm_ext,
   input  logic [JIDX_W-1:0] jidx,
   output logic [XLEN-1:0]   branch_tgt,
   output logic [XLEN-1:0]   jump_tgt
);
   localparam int REGION_W = XLEN - JIDX_W - ALIGN;

   if (REGION_W < 1) begin : g_bad_region
      $error("mdec_targets: no room for the PC region bits");
   end

   assign branch_tgt = pc_plus4 + (imm_ext << ALIGN);

   if (ALIGN == 0) begin : g_noalign
      assign jump_tgt = {pc_plus4[XLEN-1 -: REGION_W], jidx};
   end else begin : g_align
      assign jump_tgt = {pc_plus4[XLEN-1 -: REGION_W], jidx, {ALIGN{1'b0}}};
   end
endmodule

// File: rtl/mdec_decode.sv
module mdec_decode #(
   parameter int XLEN   = 32,
   parameter int REG_AW = 5,
   parameter int IMM_W  = 16,
   parameter int ALIGN  = 2
) (
   input  logic [31:0] instr_i,
   input  logic [31:0] pc_plus4_i,
   output logic [5:0]  opcode_o,
   output logic [4:0]  rs_o,
   output logic [4:0]  rt_o,
   output logic [4:0]  rd_o,
   output logic [5:0]  funct_o,
   output logic [15:0] imm_o,
   output logic        reg_dst_o,
   output logic        alu_src_o,
   output logic        mem_to_reg_o,
   output logic        reg_write_o,
   output logic        mem_read_o,
   output logic        mem_write_o,
   output logic        branch_o,
   output logic        jump_o,
   output logic [1:0]  alu_op_o,
   output logic [3:0]  alu_ctl_o,
   output logic [4:0]  wr_reg_o,
   output logic [31:0] imm_ext_o,
   output logic [31:0] branch_tgt_o,
   output logic [31:0] jump_tgt_o
);
   import mdec_pkg::*;

   localparam int OPC_W  = 6;
   localparam int FN_W   = 6;
   localparam int JIDX_W = XLEN - OPC_W;

   if (XLEN != 32) begin : g_bad_xlen
      $error("mdec_decode: the encoding is defined for 32-bit words");
   end
   if (REG_AW != 5 || IMM_W != 16) begin : g_bad_fields
      $error("mdec_decode: field widths are fixed by the encoding");
   end

   logic [JIDX_W-1:0] jidx;
   ctrl_t             ctrl;
   alu_ctl_e          alu_ctl;

   mdec_fields #(
      .INSTR_W (XLEN), .OPC_W (OPC_W), .REG_AW (REG_AW),
      .FN_W (FN_W), .IMM_W (IMM_W), .JIDX_W (JIDX_W)
   ) u_fields (
      .instr (instr_i), .opcode (opcode_o), .rs (rs_o), .rt (rt_o),
      .rd (rd_o), .funct (funct_o), .imm (imm_o), .jidx (jidx)
   );

   mdec_main_ctrl u_main (
      .opcode (opcode_o),
      .ctrl   (ctrl)
   );

   mdec_alu_ctrl u_aluc (
      .alu_cls (ctrl.alu_cls),
      .funct   (funct_o),
      .alu_ctl (alu_ctl)
   );

   mdec_sext #(.IN_W (IMM_W), .OUT_W (XLEN), .SIGNED (1'b1)) u_sext (
      .din  (imm_o),
      .dout (imm_ext_o)
   );

   mdec_targets #(.XLEN (XLEN), .JIDX_W (JIDX_W), .ALIGN (ALIGN)) u_tgt (
      .pc_plus4   (pc_plus4_i),
      .imm_ext    (imm_ext_o),
      .jidx       (jidx),
      .branch_tgt (branch_tgt_o),
      .jump_tgt   (jump_tgt_o)
   );

   assign wr_reg_o     = ctrl.reg_dst ? rd_o : rt_o;
   assign reg_dst_o    = ctrl.reg_dst;
   assign alu_src_o    = ctrl.alu_src;
   assign mem_to_reg_o = ctrl.mem_to_reg;
   assign reg_write_o  = ctrl.reg_write;
   assign mem_read_o   = ctrl.mem_read;
   assign mem_write_o  = ctrl.mem_write;
   assign branch_o     = ctrl.branch;
   assign jump_o       = ctrl.jump;
   assign alu_op_o     = ctrl.alu_cls;
   assign alu_ctl_o    = alu_ctl;
endmodule

// File: rtl/mdec_decode_chk.sv
module mdec_decode_chk (
   input logic [31:0] instr_i,
   input logic [31:0] pc_plus4_i,
   input logic [5:0]  opcode_o,
   input logic [4:0]  rs_o,
   input logic [4:0]  rd_o,
   input logic        reg_dst_o,
   input logic        alu_src_o,
   input logic        mem_to_reg_o,
   input logic        reg_write_o,
   input logic        mem_read_o,
   input logic        mem_write_o,
   input logic        branch_o,
   input logic        jump_o,
   input logic [1:0]  alu_op_o,
   input logic [4:0]  wr_reg_o,
   input logic [31:0] imm_ext_o,
   input logic [31:0] branch_tgt_o,
   input logic [31:0] jump_tgt_o
);
   logic known;
   assign known = opcode_o inside {6'b000000, 6'b001000, 6'b100011,
                                   6'b101011, 6'b000100, 6'b000010};

   always_comb begin
      AST_FIELD_SPLIT: assert (opcode_o == instr_i[31:26] && rs_o == instr_i[25:21]) // R1
         else $error("opcode/rs not taken from their bit positions");
      AST_RTYPE_CLASS: assert (opcode_o != 6'b0 || alu_op_o == 2'b10) // R2
         else $error("R-type did not select funct-based ALU class");
      AST_MEM_EXCL: assert (!(mem_read_o && mem_write_o)) // R3
         else $error("memory read and write both asserted");
      AST_NO_WRITE_ON_STORE: assert (!mem_write_o || !reg_write_o) // R4
         else $error("store also writes the register file");
      AST_UNKNOWN_QUIET: assert (known || {reg_dst_o, alu_src_o, mem_to_reg_o, reg_write_o,
                                           mem_read_o, mem_write_o, branch_o, jump_o,
                                           alu_op_o} == 10'b0) // R8
         else $error("undefined opcode left a control asserted");
      AST_WREG_RD: assert (!reg_dst_o || wr_reg_o == rd_o) // R11
         else $error("write register is not rd");
      AST_SEXT_UPPER: assert (imm_ext_o[31:16] == {16{instr_i[15]}}) // R12
         else $error("upper immediate bits do not follow bit 15");
      AST_BR_ALIGN: assert (branch_tgt_o[1:0] == pc_plus4_i[1:0]) // R13
         else $error("branch target changed the low address bits");
      AST_JMP_REGION: assert (jump_tgt_o[31:28] == pc_plus4_i[31:28] && jump_tgt_o[1:0] == 2'b00) // R14
         else $error("jump target left its region or is misaligned");
   end
endmodule

bind mdec_decode mdec_decode_chk u_chk (
   .instr_i      (instr_i),
   .pc_plus4_i   (pc_plus4_i),
   .opcode_o     (opcode_o),
   .rs_o         (rs_o),
   .rd_o         (rd_o),
   .reg_dst_o    (reg_dst_o),
   .alu_src_o    (alu_src_o),
   .mem_to_reg_o (mem_to_reg_o),
   .reg_write_o  (reg_write_o),
   .mem_read_o   (mem_read_o),
   .mem_write_o  (mem_write_o),
   .branch_o     (branch_o),
   .jump_o       (jump_o),
   .alu_op_o     (alu_op_o),
   .wr_reg_o     (wr_reg_o),
   .imm_ext_o    (imm_ext_o),
   .branch_tgt_o (branch_tgt_o),
   .jump_tgt_o   (jump_tgt_o)
);

// File: tb/mdec_decode_bench.sv
module mdec_decode_bench;
   logic        clk = 1'b0;
   always #2.5 clk = ~clk;

   logic [31:0] instr_i = '0;
   logic [31:0] pc_plus4_i = '0;
   logic [5:0]  opcode_o, funct_o;
   logic [4:0]  rs_o, rt_o, rd_o, wr_reg_o;
   logic [15:0] imm_o;
   logic        reg_dst_o, alu_src_o, mem_to_reg_o, reg_write_o;
   logic        mem_read_o, mem_write_o, branch_o, jump_o;
   logic [1:0]  alu_op_o;
   logic [3:0]  alu_ctl_o;
   logic [31:0] imm_ext_o, branch_tgt_o, jump_tgt_o;

   mdec_decode u_mdec_decode (
      .instr_i (instr_i), .pc_plus4_i (pc_plus4_i),
      .opcode_o (opcode_o), .rs_o (rs_o), .rt_o (rt_o), .rd_o (rd_o),
      .funct_o (funct_o), .imm_o (imm_o),
      .reg_dst_o (reg_dst_o), .alu_src_o (alu_src_o), .mem_to_reg_o (mem_to_reg_o),
      .reg_write_o (reg_write_o), .mem_read_o (mem_read_o), .mem_write_o (mem_write_o),
      .branch_o (branch_o), .jump_o (jump_o), .alu_op_o (alu_op_o),
      .alu_ctl_o (alu_ctl_o), .wr_reg_o (wr_reg_o), .imm_ext_o (imm_ext_o),
      .branch_tgt_o (branch_tgt_o), .jump_tgt_o (jump_tgt_o)
   );

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;
   int cycles = 0;
   logic [31:0] seed = 32'h1234_5678;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h (instr %h pc4 %h)", req, act, exp, instr_i, pc_plus4_i);
      end
   endtask

   task automatic apply(input logic [31:0] ins, input logic [31:0] pc4);
      @(negedge clk);
      instr_i = ins;
      pc_plus4_i = pc4;
      #1;
   endtask

   function automatic logic [31:0] next_rand(input logic [31:0] s);
      return s * 32'd1664525 + 32'd1013904223;
   endfunction

   // control word in bench order {dst,src,m2r,rw,mr,mw,br,j,op[1:0]}
   function automatic logic [9:0] exp_ctrl(input logic [5:0] op);
      case (op)
         6'd0:  return 10'b1001_0000_10; // R2
         6'd35: return 10'b0111_1000_00; // R3
         6'd43: return 10'b0100_0100_00; // R4
         6'd4:  return 10'b0000_0010_01; // R5
         6'd8:  return 10'b0101_0000_00; // R6
         6'd2:  return 10'b0000_0001_00; // R7
         default: return 10'b0;           // R8
      endcase
   endfunction

   function automatic string ctrl_tag(input logic [5:0] op);
      case (op)
         6'd0: return "R2"; 6'd35: return "R3"; 6'd43: return "R4";
         6'd4: return "R5"; 6'd8:  return "R6"; 6'd2:  return "R7";
         default: return "R8";
      endcase
   endfunction

   function automatic logic [3:0] exp_alu(input logic [1:0] cls, input logic [5:0] fn);
      if (cls == 2'b00) return 4'd2;
      if (cls == 2'b01) return 4'd6;
      if (cls == 2'b11) return 4'd0;
      case (fn)
         6'd32: return 4'd2; 6'd34: return 4'd6; 6'd36: return 4'd0;
         6'd37: return 4'd1; 6'd42: return 4'd7;
         default: return 4'd0;
      endcase
   endfunction

   always @(posedge clk) begin
      cycles++;
      if (!done && cycles > 100000) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      logic [9:0]  ec;
      logic [31:0] ins, pc4, iext;

      // all-zero word: R-type with funct 000000
      apply(32'h0, 32'h0);
      chk("R2 zero word ctrl", 32'({reg_dst_o, alu_src_o, mem_to_reg_o, reg_write_o, mem_read_o,
                                   mem_write_o, branch_o, jump_o, alu_op_o}), 32'(exp_ctrl(6'd0)));
      chk("R10 zero funct alu", 32'(alu_ctl_o), 32'd0);

      // opcode sweep
      for (int op = 0; op < 64; op++) begin
         seed = next_rand(seed);
         ins = {6'(op), seed[25:0]};
         apply(ins, seed ^ 32'hA5A5_0000);
         ec = exp_ctrl(6'(op));
         chk({ctrl_tag(6'(op)), " ctrl"}, 32'({reg_dst_o, alu_src_o, mem_to_reg_o, reg_write_o,
             mem_read_o, mem_write_o, branch_o, jump_o, alu_op_o}), 32'(ec));
         chk(ec[1:0] == 2'b10 ? "R10 alu" : "R9 alu", 32'(alu_ctl_o), 32'(exp_alu(ec[1:0], ins[5:0])));
         chk("R1 fields", {opcode_o, rs_o, rt_o, rd_o, funct_o[5:0], 5'b0},
             {ins[31:26], ins[25:21], ins[20:16], ins[15:11], ins[5:0], 5'b0});
         chk("R1 imm", 32'(imm_o), 32'(ins & 32'hFFFF));
         chk("R11 wreg", 32'(wr_reg_o), 32'(ec[9] ? ins[15:11] : ins[20:16]));
      end

      // funct sweep under R-type
      for (int fn = 0; fn < 64; fn++) begin
         seed = next_rand(seed);
         ins = {6'b0, seed[25:6], 6'(fn)};
         apply(ins, 32'h0040_0004);
         chk("R10 funct alu", 32'(alu_ctl_o), 32'(exp_alu(2'b10, 6'(fn))));
         chk("R11 rtype wreg", 32'(wr_reg_o), 32'(ins[15:11]));
      end

      // immediate and target sweep
      for (int k = 0; k < 1024; k++) begin
         logic [15:0] im;
         seed = next_rand(seed);
         im = 16'(k * 64) | 16'(k % 64);
         if (k == 1) im = 16'h7FFF;
         if (k == 2) im = 16'h8000;
         if (k == 3) im = 16'hFFFF;
         pc4 = {seed[31:2], 2'b00};
         if (k == 4) pc4 = 32'hFFFF_FFFC;
         ins = {(k % 2 == 0) ? 6'd4 : 6'd2, seed[9:0], im};
         apply(ins, pc4);
         iext = (int'($signed(im)) < 0) ? (32'hFFFF_0000 | 32'(im)) : 32'(im);
         chk("R12 sext", imm_ext_o, iext);
         chk("R13 branch", branch_tgt_o, pc4 + iext * 32'd4);
         chk("R14 jump", jump_tgt_o, (pc4 & 32'hF000_0000) | ((ins & 32'h03FF_FFFF) << 2));
      end

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule